// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line that idles high. A sample-rate enable tick, produced outside the block, marks 16 samples per bit period in normal mode or 8 in double-speed mode. The line first passes through a two-flop synchronizer. The receiver then watches for a high-to-low change and counts samples from the first low one. The start bit, every data bit, the optional parity bit and the stop bit are each decided by a two-of-three majority over three fixed middle samples. The positions of those samples depend on the mode.

A start bit that fails the vote is treated as a noise spike, and the receiver goes back to searching for an edge. Every accepted frame restarts the sample counter, so timing is realigned on each start bit. Completed frames go into a two-entry buffer. Each entry holds the data word with its own parity-error and framing-error flags. The buffer is read through a valid/ready output. `rd_valid` is high exactly while the buffer holds a frame. A frame is taken from the buffer on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, the head entry and its flags stay unchanged. A frame that completes while the buffer is full, and no entry leaves on that same edge, is discarded. Reading until `rd_valid` falls empties the buffer. Dropping `rx_en` empties it at once.

Top module: `serial_rx_ovs`

## Requirements
- R1: After reset, `rd_valid` is low, and no frame appears until a start bit has been received.
- R2: A start bit is detected on a sample tick where the synchronized line is low and the previous tick's sample was high; that low sample is sample 1 of the start bit. The start bit is accepted when at least two of samples 8, 9 and 10 are low (`dbl_speed`=0), or of samples 4, 5 and 6 (`dbl_speed`=1). A line low for samples 1..(mid+1) only, where mid is 8 or 4, is therefore accepted.
- R3: When at least two of the judged start samples are high, the start is dropped and nothing is stored. The receiver then waits for a new high-to-low change; a low pulse covering samples 1..mid only is rejected.
- R4: `data_bits_sel` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits. Data arrives LSB first into `rd_data[0]` upward, and `rd_data` bits at or above the selected width read 0.
- R5: Each data, parity and stop bit is decided by a two-of-three majority over the same sample positions used for the start bit, and one inverted sample among those three does not change the decided value.
- R6: With `parity_en`=1, one parity bit follows the data. In even mode (`parity_odd`=0) the expected parity bit equals the XOR of the data bits, and in odd mode it equals the complement of that XOR. `rd_perr` is 1 exactly when the received parity bit differs from the expected one. With `parity_en`=0, no parity bit is received and `rd_perr` is 0.
- R7: A stop bit decided low sets `rd_ferr` on that frame, and the frame is still stored. After such a stop bit, the line must return high before another start bit can be detected.
- R8: The buffer holds two frames in arrival order, each with its own flags. `rd_valid` is high exactly while an entry is held, and the head stays stable while `rd_ready` is low. An entry leaves on an edge where `rd_valid` and `rd_ready` are both high. A frame completing while the buffer is full, with no entry leaving on that edge, is discarded.
- R9: With `rx_en` low, the buffer is emptied (`rd_valid` is low from the next cycle), any frame in progress is abandoned, and line activity is ignored.
- R10: Each start bit restarts the sample counter, so frames sent back to back, each starting directly after the previous stop bit, are all received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low flushes the buffer and abandons the current frame |
| dbl_speed | input | 1 | 0: 16 samples per bit; 1: 8 samples per bit |
| sample_tick | input | 1 | One-cycle pulse per sample period |
| data_bits_sel | input | 2 | Data width select: 0..3 gives 5..8 bits |
| parity_en | input | 1 | Enables reception and checking of a parity bit |
| parity_odd | input | 1 | 0: even parity, 1: odd parity |
| rxd | input | 1 | Serial line, idle high, not synchronized |
| rd_valid | output | 1 | Buffer holds at least one frame |
| rd_ready | input | 1 | Consumer accepts the head frame |
| rd_data | output | 8 | Data of the head frame |
| rd_perr | output | 1 | Parity error flag of the head frame |
| rd_ferr | output | 1 | Framing error flag of the head frame |

## Verification
The bench builds the block with its default parameters: 5 to 8 data bits, 16 or 8 samples per bit, a two-stage synchronizer and a two-entry buffer. At these values both oversampling modes, every data width and every parity mode can be swept completely, and all 32 data words can be sent in 5-bit double-speed mode. Start pulses one sample shorter than, and exactly as long as, the acceptance threshold can both be placed at the judged positions. A third unread frame is enough to reach the full-buffer drop.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '1;
    end else begin
      q[0] <= din;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_phase_ctr.sv
module rx_phase_ctr #(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic dbl,
  output logic at_j0,
  output logic at_j1,
  output logic at_j2,
  output logic at_end
);
  localparam int CW = $clog2(OSR_NORM + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] osr_v;
  logic [CW-1:0] mid_v;
  logic          step;

  assign osr_v = dbl ? CW'(OSR_FAST) : CW'(OSR_NORM);
  assign mid_v = osr_v >> 1;
  assign step  = run & tick;

  // cnt holds the index of the sample taken at the next tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= CW'(2);
    else if (step)     cnt <= (cnt == osr_v) ? CW'(1) : cnt + 1'b1;
  end

  assign at_j0  = step & (cnt == mid_v);
  assign at_j1  = step & (cnt == mid_v + CW'(1));
  assign at_j2  = step & (cnt == mid_v + CW'(2));
  assign at_end = step & (cnt == osr_v);
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import serial_rx_pkg::*;
#(
  parameter int DATA_MIN = 5,
  parameter int DATA_MAX = 8,
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic                dbl,
  input  logic [SEL_W-1:0]    wsel,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                rxd,
  output logic                push,
  output logic [DATA_MAX-1:0] push_data,
  output logic                push_perr,
  output logic                push_ferr
);
  localparam int IDX_W = $clog2(DATA_MAX);

  rx_state_e           state;
  logic                line_prev;
  logic                s_first, s_second, pbit;
  logic [IDX_W-1:0]    bidx;
  logic [DATA_MAX-1:0] shr;
  logic [IDX_W:0]      nbits;
  logic                at_j0, at_j1, at_j2, at_end;
  logic                run, restart, vote, last_bit, exp_par;

  assign nbits    = (IDX_W+1)'(DATA_MIN) + (IDX_W+1)'(wsel);
  assign last_bit = ({1'b0, bidx} == nbits - 1'b1);
  assign run      = en && (state != RX_IDLE);
  assign restart  = en && (state == RX_IDLE) && tick && line_prev && !rxd;
  assign vote     = maj3(s_first, s_second, rxd);
  assign exp_par  = (^shr) ^ par_odd;

  rx_phase_ctr #(
    .OSR_NORM (OSR_NORM),
    .OSR_FAST (OSR_FAST)
  ) phase_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .restart (restart),
    .dbl     (dbl),
    .at_j0   (at_j0),
    .at_j1   (at_j1),
    .at_j2   (at_j2),
    .at_end  (at_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      line_prev <= 1'b0;
      s_first   <= 1'b0;
      s_second  <= 1'b0;
      pbit      <= 1'b0;
      bidx      <= '0;
      shr       <= '0;
      push      <= 1'b0;
      push_data <= '0;
      push_perr <= 1'b0;
      push_ferr <= 1'b0;
    end else if (!en) begin
      state     <= RX_IDLE;
      line_prev <= 1'b0;
      push      <= 1'b0;
    end else begin
      push <= 1'b0;
      if (at_j0) s_first  <= rxd;
      if (at_j1) s_second <= rxd;
      unique case (state)
        RX_IDLE: begin
          if (tick) begin
            line_prev <= rxd;
            if (restart) begin
              state <= RX_START;
              shr   <= '0;
              bidx  <= '0;
            end
          end
        end
        RX_START: begin
          if (at_j2 && vote) begin
            state     <= RX_IDLE;
            line_prev <= rxd;
          end else if (at_end) begin
            state <= RX_DATA;
          end
        end
        RX_DATA: begin
          if (at_j2) shr[bidx] <= vote;
          if (at_end) begin
            if (last_bit) state <= par_en ? RX_PAR : RX_STOP;
            else          bidx  <= bidx + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_j2)  pbit  <= vote;
          if (at_end) state <= RX_STOP;
        end
        RX_STOP: begin
          if (at_j2) begin
            push      <= 1'b1;
            push_data <= shr;
            push_perr <= par_en && (pbit != exp_par);
            push_ferr <= !vote;
            state     <= RX_IDLE;
            line_prev <= rxd;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WIDTH-1:0]           out_data,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             pop, do_push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (occ != '0);
  assign out_data  = mem[rp];
  assign pop       = out_valid & out_ready;
  assign do_push   = wr_en & ((occ < CW'(DEPTH)) | pop);

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (pop)     rp <= nxt(rp);
      occ <= occ + CW'(do_push) - CW'(pop);
    end
  end
endmodule

// File: rtl/serial_rx_ovs.sv
module serial_rx_ovs
  import serial_rx_pkg::*;
#(
  parameter int DATA_MIN    = 5,
  parameter int DATA_MAX    = 8,
  parameter int OSR_NORM    = 16,
  parameter int OSR_FAST    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BUF_DEPTH   = 2,
  localparam int SEL_W      = $clog2(DATA_MAX - DATA_MIN + 1),
  localparam int ENT_W      = DATA_MAX + 2,
  localparam int OCC_W      = $clog2(BUF_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                dbl_speed,
  input  logic                sample_tick,
  input  logic [SEL_W-1:0]    data_bits_sel,
  input  logic                parity_en,
  input  logic                parity_odd,
  input  logic                rxd,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [DATA_MAX-1:0] rd_data,
  output logic                rd_perr,
  output logic                rd_ferr
);
  logic                rx_s;
  logic                push_w, push_perr_w, push_ferr_w;
  logic [DATA_MAX-1:0] push_data_w;
  logic [ENT_W-1:0]    head_w;
  logic [OCC_W-1:0]    occ_w;

  rx_line_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rxd),
    .dout  (rx_s)
  );

  rx_frame_engine #(
    .DATA_MIN (DATA_MIN),
    .DATA_MAX (DATA_MAX),
    .OSR_NORM (OSR_NORM),
    .OSR_FAST (OSR_FAST),
    .SEL_W    (SEL_W)
  ) engine_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .tick      (sample_tick),
    .dbl       (dbl_speed),
    .wsel      (data_bits_sel),
    .par_en    (parity_en),
    .par_odd   (parity_odd),
    .rxd       (rx_s),
    .push      (push_w),
    .push_data (push_data_w),
    .push_perr (push_perr_w),
    .push_ferr (push_ferr_w)
  );

  rx_frame_fifo #(
    .WIDTH (ENT_W),
    .DEPTH (BUF_DEPTH)
  ) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!rx_en),
    .wr_en     (push_w),
    .wr_data   ({push_perr_w, push_ferr_w, push_data_w}),
    .out_valid (rd_valid),
    .out_ready (rd_ready),
    .out_data  (head_w),
    .occ       (occ_w)
  );

  assign {rd_perr, rd_ferr, rd_data} = head_w;
endmodule

// File: rtl/serial_rx_ovs_chk.sv
module serial_rx_ovs_chk #(
  parameter int DATA_MIN  = 5,
  parameter int DATA_MAX  = 8,
  parameter int BUF_DEPTH = 2,
  parameter int SEL_W     = 2,
  parameter int OCC_W     = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_en,
  input logic                rd_valid,
  input logic                rd_ready,
  input logic [DATA_MAX-1:0] rd_data,
  input logic                parity_en,
  input logic [SEL_W-1:0]    wsel,
  input logic                push,
  input logic [DATA_MAX-1:0] push_data,
  input logic                push_perr,
  input logic [OCC_W-1:0]    occ
);
  logic [7:0] nbits;
  assign nbits = 8'(DATA_MIN) + 8'(wsel);

  assert_flush_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rd_valid)
    else $error("R9: buffer not empty after disable");

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && rx_en) |=> (rd_valid && $stable(rd_data)))
    else $error("R8: head changed while stalled");

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(BUF_DEPTH))
    else $error("R8: occupancy above depth");

  assert_no_parity_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !parity_en) |-> !push_perr)
    else $error("R6: parity error without parity");

  assert_upper_bits_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((push_data >> nbits) == '0))
    else $error("R4: data bits above width set");
endmodule

bind serial_rx_ovs serial_rx_ovs_chk #(
  .DATA_MIN  (DATA_MIN),
  .DATA_MAX  (DATA_MAX),
  .BUF_DEPTH (BUF_DEPTH),
  .SEL_W     (SEL_W),
  .OCC_W     (OCC_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .parity_en (parity_en),
  .wsel      (data_bits_sel),
  .push      (push_w),
  .push_data (push_data_w),
  .push_perr (push_perr_w),
  .occ       (occ_w)
);

// File: tb/serial_rx_ovs_tb_top.sv
module serial_rx_ovs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_ready = 1'b0;
  logic [1:0] data_bits_sel = 2'd0;
  logic [1:0] tdiv = 2'd0;
  logic       sample_tick;
  logic       rd_valid, rd_perr, rd_ferr;
  logic [7:0] rd_data;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
  assign sample_tick = (tdiv == 2'd0);

  serial_rx_ovs dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .dbl_speed     (dbl_speed),
    .sample_tick   (sample_tick),
    .data_bits_sel (data_bits_sel),
    .parity_en     (parity_en),
    .parity_odd    (parity_odd),
    .rxd           (rxd),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_data       (rd_data),
    .rd_perr       (rd_perr),
    .rd_ferr       (rd_ferr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns just after the edge that consumed a sample tick
  task automatic next_tick();
    @(negedge clk);
    while (!sample_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input int pm, input bit bad_par,
                            input bit stop_v, input bit glitch, input int idle, input int tail_low);
    int osr;
    int mid;
    int n;
    bit [11:0] bits;
    osr = dbl_speed ? 8 : 16;
    mid = osr / 2;
    n = 0;
    bits = '0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin bits[n] = d[i]; n++; end
    if (pm != 0) begin
      bits[n] = (^d) ^ (pm == 2) ^ bad_par; n++;
    end
    bits[n] = stop_v; n++;
    next_tick();
    for (int b = 0; b < n; b++) begin
      for (int s = 1; s <= osr; s++) begin
        logic v;
        v = bits[b];
        if (glitch && s == mid + (b % 3)) v = ~v;
        rxd = v;
        next_tick();
      end
    end
    rxd = 1'b0;
    repeat (tail_low) next_tick();
    rxd = 1'b1;
    repeat (idle) next_tick();
  endtask

  task automatic expect_frame(input logic [7:0] d, input bit pe, input bit fe, input string req);
    @(negedge clk);
    chk(rd_valid === 1'b1 && rd_data === d && rd_perr === pe && rd_ferr === fe, req,
        32'({rd_valid, rd_perr, rd_ferr, rd_data}), 32'({1'b1, pe, fe, d}));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(rd_valid === 1'b0, req, 32'(rd_valid), 32'd0);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] mask;
    logic [7:0] d;
    int nb, mid, osr;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R1 reset state", 32'(rd_valid), 32'd0);
    rx_en = 1'b1;
    repeat (8) next_tick();
    expect_empty("R1 idle line gives no frame");

    // R4 R5 R6: sweep over mode, width, parity mode and data patterns
    for (int m = 0; m < 2; m++) begin
      dbl_speed = m[0];
      for (int w = 0; w < 4; w++) begin
        data_bits_sel = w[1:0];
        nb = 5 + w;
        mask = 8'((1 << nb) - 1);
        for (int pm = 0; pm < 3; pm++) begin
          parity_en  = (pm != 0);
          parity_odd = (pm == 2);
          for (int k = 0; k < 3; k++) begin
            bit bad;
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((m * 53 + w * 29 + pm * 17 + 11) & 255);
            d = d & mask;
            bad = (pm != 0) && (k == 2);
            send_frame(d, nb, pm, bad, 1'b1, k >= 1, 2, 0);
            expect_frame(d, bad, 1'b0,
                         $sformatf("R4/R5/R6 m%0d w%0d p%0d k%0d", m, w, pm, k));
            expect_empty("R8 empty after read");
          end
        end
      end
    end

    // near-exhaustive: every 5-bit word, double speed, even parity
    dbl_speed = 1'b1; data_bits_sel = 2'd0; parity_en = 1'b1; parity_odd = 1'b0;
    for (int v = 0; v < 32; v++) begin
      send_frame(8'(v), 5, 1, 1'b0, 1'b1, v[0], 1, 0);
      expect_frame(8'(v), 1'b0, 1'b0, $sformatf("R4/R6 word %0d", v));
    end

    // R2 and R3: start pulse length at the acceptance boundary, both modes
    data_bits_sel = 2'd3; parity_en = 1'b0; parity_odd = 1'b0;
    for (int m = 0; m < 2; m++) begin
      dbl_speed = m[0];
      osr = m ? 8 : 16;
      mid = osr / 2;
      next_tick();
      rxd = 1'b0; repeat (mid) next_tick();
      rxd = 1'b1; repeat (14 * osr) next_tick();
      expect_empty($sformatf("R3 spike of %0d samples rejected", mid));
      send_frame(8'h5A, 8, 0, 1'b0, 1'b1, 1'b0, 2, 0);
      expect_frame(8'h5A, 1'b0, 1'b0, "R3 frame after rejected spike");
      next_tick();
      rxd = 1'b0; repeat (mid + 1) next_tick();
      rxd = 1'b1; repeat (12 * osr) next_tick();
      expect_frame(8'hFF, 1'b0, 1'b0, $sformatf("R2 start of %0d samples accepted", mid + 1));
      expect_empty("R2 single frame");
    end

    // R7: framing error, line held low afterwards
    dbl_speed = 1'b0;
    send_frame(8'hA5, 8, 0, 1'b0, 1'b0, 1'b1, 4, 40);
    expect_frame(8'hA5, 1'b0, 1'b1, "R7 framing error stored");
    expect_empty("R7 no start while line stays low");
    send_frame(8'h3C, 8, 0, 1'b0, 1'b1, 1'b0, 2, 0);
    expect_frame(8'h3C, 1'b0, 1'b0, "R7 recovery after framing error");

    // R8: two entries kept in order with own flags, third dropped
    parity_en = 1'b1; parity_odd = 1'b1;
    send_frame(8'h81, 8, 2, 1'b1, 1'b1, 1'b0, 2, 0);
    send_frame(8'h42, 8, 2, 1'b0, 1'b0, 1'b0, 2, 0);
    send_frame(8'h24, 8, 2, 1'b0, 1'b1, 1'b0, 2, 0);
    expect_frame(8'h81, 1'b1, 1'b0, "R8 first entry");
    expect_frame(8'h42, 1'b0, 1'b1, "R8 second entry");
    expect_empty("R8 third frame dropped when full");

    // R10: back-to-back frames in both modes
    parity_en = 1'b0;
    for (int m = 0; m < 2; m++) begin
      dbl_speed = m[0];
      send_frame(8'hC3, 8, 0, 1'b0, 1'b1, 1'b1, 0, 0);
      send_frame(8'h1E, 8, 0, 1'b0, 1'b1, 1'b1, 0, 0);
      expect_frame(8'hC3, 1'b0, 1'b0, "R10 back-to-back first");
      expect_frame(8'h1E, 1'b0, 1'b0, "R10 back-to-back second");
    end

    // R9: disable flushes the buffer
    dbl_speed = 1'b0;
    send_frame(8'h11, 8, 0, 1'b0, 1'b1, 1'b0, 2, 0);
    send_frame(8'h22, 8, 0, 1'b0, 1'b1, 1'b0, 2, 0);
    @(negedge clk);
    chk(rd_valid === 1'b1, "R9 buffer filled before disable", 32'(rd_valid), 32'd1);
    rx_en = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R9 flush on disable", 32'(rd_valid), 32'd0);
    rx_en = 1'b1;
    repeat (4) next_tick();
    expect_empty("R9 stays empty after enable");

    // R9: frame abandoned mid-way and line ignored while disabled
    next_tick();
    rxd = 1'b0; repeat (16) next_tick();
    for (int i = 0; i < 3; i++) begin rxd = i[0]; repeat (16) next_tick(); end
    rx_en = 1'b0;
    rxd = 1'b0; repeat (40) next_tick();
    rxd = 1'b1; repeat (10) next_tick();
    rxd = 1'b0; repeat (20) next_tick();
    rxd = 1'b1; repeat (40) next_tick();
    rx_en = 1'b1;
    repeat (200) next_tick();
    expect_empty("R9 abandoned frame not stored");
    send_frame(8'h96, 8, 0, 1'b0, 1'b1, 1'b0, 2, 0);
    expect_frame(8'h96, 1'b0, 1'b0, "R9 reception after re-enable");

    done = 1'b1;
    report();
    $finish;
  end
endmodule